// File: doc/BRIEF.md
# Receive Line Break and Active-Edge Monitor

This block sits beside a UART receiver and watches the receive pin for two line-level events, without looking at characters. The first event is a break: a run of logic-0 data bits long enough that no valid character could hold it. The run is counted once per bit period, on a sample strobe that the receiver's bit timing supplies. The run needed is 11 bits in 8-bit character mode and 12 bits in 9-bit character mode. The second event is an active edge on the pin. Software or a low-power controller uses this event to learn that traffic has started.

Each event latches a sticky flag. Software clears a flag by writing a 1 to that flag's bit on a simple write strobe. A single interrupt request combines the two flags, each gated by its own enable. The pin passes through a synchronizer before any detection. When receive inversion is on, the data level is the inverse of the pin level, and the active edge changes from falling to rising.

Top module: `rx_line_monitor`

## Requirements
- R1: After reset both flags and the interrupt request are 0.
- R2: In 8-bit mode (`char9_i`=0), the break flag sets on the sample strobe that takes in the 11th consecutive 0 data bit. The data bit is the synchronized pin level XOR `rx_inv_i`, taken only when `bit_tick_i` is high. After 10 zeros the flag is still 0.
- R3: In 9-bit mode (`char9_i`=1), the break flag sets on the 12th consecutive 0 data bit and not on the 11th.
- R4: The break flag can set only while `brk_en_i` is 1 on the strobe that completes the run. Any sampled 1 restarts the run. One unbroken run of zeros sets the flag at most once, even if the flag is cleared while the run goes on.
- R5: With `rx_inv_i`=0 the edge flag sets on a falling edge of the pin, and with `rx_inv_i`=1 on a rising edge. An edge in the other direction has no effect. The pin is synchronized by two flops, so the flag shows the edge within three clocks.
- R6: Pin edges have no effect on the edge flag while `two_wire_i` is 0.
- R7: A cycle with `wr_en_i`=1 clears the break flag if `wr_data_i[7]` is 1 and clears the edge flag if `wr_data_i[6]` is 1. A 0 in either of those bits leaves that flag unchanged.
- R8: If a flag's set event and its write-1 clear fall in the same cycle, the flag ends up 1.
- R9: `irq_o` is 1 exactly when (break flag AND `brk_irq_en_i`) OR (edge flag AND `edge_irq_en_i`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_pin_i | input | 1 | Raw receive pin, asynchronous |
| bit_tick_i | input | 1 | One-cycle strobe per bit period, when the data bit is sampled |
| char9_i | input | 1 | 1 selects 9-bit characters (12-bit break), 0 selects 8-bit (11-bit break) |
| brk_en_i | input | 1 | Break detection enable |
| rx_inv_i | input | 1 | Receive inversion: data is pin inverted, active edge is rising |
| two_wire_i | input | 1 | 1 enables active-edge detection |
| brk_irq_en_i | input | 1 | Interrupt enable for the break flag |
| edge_irq_en_i | input | 1 | Interrupt enable for the edge flag |
| wr_en_i | input | 1 | Status write strobe |
| wr_data_i | input | 8 | Write data; bit 7 clears the break flag, bit 6 clears the edge flag |
| brk_flag_o | output | 1 | Break detected flag |
| edge_flag_o | output | 1 | Active edge detected flag |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench uses the default parameters: 11- and 12-bit break lengths, two synchronizer stages, and an 8-bit write port with the flags in bits 7 and 6. With these values the 4-bit run counter reaches its saturation value of 15 during long random zero runs. This lets the bench check that a run set once stays quiet while the counter sits at the limit. The short break lengths also let random bit streams, weighted toward zeros, cross both thresholds often. Mode, enable and inversion changes land in the middle of runs, so the bench also reaches a threshold crossed by a mode switch and a run completed while detection is off.

// File: rtl/rlm_pkg.sv
package rlm_pkg;
  // default break run lengths, in bit periods
  localparam int unsigned BRK_LEN_8 = 11;
  localparam int unsigned BRK_LEN_9 = 12;
  // status write port layout
  localparam int unsigned WR_W      = 8;
  localparam int unsigned BRK_POS   = 7;
  localparam int unsigned EDGE_POS  = 6;

  typedef enum logic {
    CHAR_8 = 1'b0,
    CHAR_9 = 1'b1
  } char_mode_e;
endpackage

// File: rtl/rlm_sync.sv
module rlm_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  always_comb begin
    stg_d[0] = d_i;
    for (int i = 1; i < STAGES; i++) begin
      stg_d[i] = stg_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
    else         stg_q <= stg_d;
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/rlm_break_ctr.sv
module rlm_break_ctr
  import rlm_pkg::*;
#(
  parameter int unsigned LEN_8 = BRK_LEN_8,
  parameter int unsigned LEN_9 = BRK_LEN_9
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       data_i,
  input  char_mode_e mode_i,
  input  logic       en_i,
  output logic       set_o
);
  localparam int unsigned CNT_W = $clog2(LEN_9 + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] THR_8   = CNT_W'(LEN_8);
  localparam logic [CNT_W-1:0] THR_9   = CNT_W'(LEN_9);

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, thr;
  logic             at_max;

  always_comb begin
    thr     = (mode_i == CHAR_9) ? THR_9 : THR_8;
    at_max  = (cnt_q == CNT_MAX);
    cnt_inc = at_max ? cnt_q : cnt_q + 1'b1;
    cnt_d   = cnt_q;
    if (tick_i) begin
      cnt_d = data_i ? '0 : cnt_inc;
    end
    set_o = tick_i && !data_i && en_i && !at_max && (cnt_inc == thr);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R4
  run_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && data_i) |=> (cnt_q == '0));

  // R2
  set_at_thr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_o |=> (cnt_q == $past(thr)));
endmodule

// File: rtl/rlm_edge_det.sv
module rlm_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic rising_i,
  input  logic en_i,
  output logic hit_o
);
  logic prev_q;
  logic fall, rise;

  always_comb begin
    fall  = prev_q && !pin_i;
    rise  = !prev_q && pin_i;
    hit_o = en_i && (rising_i ? rise : fall);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= pin_i;
  end
endmodule

// File: rtl/rlm_flag.sv
module rlm_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d;

  always_comb begin
    q_d = q_o;
    if (set_i)      q_d = 1'b1;
    else if (clr_i) q_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= q_d;
  end

  // R8
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);

  // R7
  w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !q_o);

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/rx_line_monitor.sv
module rx_line_monitor
  import rlm_pkg::*;
#(
  parameter int unsigned LEN_8       = BRK_LEN_8,
  parameter int unsigned LEN_9       = BRK_LEN_9,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DATA_W      = WR_W,
  parameter int unsigned BRK_BIT     = BRK_POS,
  parameter int unsigned EDGE_BIT    = EDGE_POS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_pin_i,
  input  logic              bit_tick_i,
  input  logic              char9_i,
  input  logic              brk_en_i,
  input  logic              rx_inv_i,
  input  logic              two_wire_i,
  input  logic              brk_irq_en_i,
  input  logic              edge_irq_en_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              brk_flag_o,
  output logic              edge_flag_o,
  output logic              irq_o
);
  logic       pin_s;
  logic       data_lvl;
  logic       brk_set, edge_set;
  logic       brk_clr, edge_clr;
  char_mode_e mode;

  rlm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_pin_i),
    .q_o   (pin_s)
  );

  always_comb begin
    data_lvl = pin_s ^ rx_inv_i;
    mode     = char9_i ? CHAR_9 : CHAR_8;
    brk_clr  = wr_en_i && wr_data_i[BRK_BIT];
    edge_clr = wr_en_i && wr_data_i[EDGE_BIT];
  end

  rlm_break_ctr #(.LEN_8(LEN_8), .LEN_9(LEN_9)) u_brk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(bit_tick_i),
    .data_i(data_lvl),
    .mode_i(mode),
    .en_i  (brk_en_i),
    .set_o (brk_set)
  );

  rlm_edge_det u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_i   (pin_s),
    .rising_i(rx_inv_i),
    .en_i    (two_wire_i),
    .hit_o   (edge_set)
  );

  rlm_flag u_brk_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (brk_set),
    .clr_i (brk_clr),
    .q_o   (brk_flag_o)
  );

  rlm_flag u_edge_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (edge_set),
    .clr_i (edge_clr),
    .q_o   (edge_flag_o)
  );

  assign irq_o = (brk_flag_o && brk_irq_en_i) || (edge_flag_o && edge_irq_en_i);

  // R4
  brk_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(brk_flag_o) |-> $past(brk_en_i));

  // R6
  edge_needs_2w_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(edge_flag_o) |-> $past(two_wire_i));

  // R2
  brk_needs_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(brk_flag_o) |-> $past(bit_tick_i));
endmodule

// File: tb/rx_line_monitor_tb_top.sv
`timescale 1ns/1ps
module rx_line_monitor_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b1, tick = 1'b0, char9 = 1'b0, brk_en = 1'b0;
  logic       inv = 1'b0, two_w = 1'b0, ie_b = 1'b0, ie_e = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       brk_f, edge_f, irq;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  int m_cnt = 0;
  bit m_brk = 1'b0, m_edge = 1'b0;

  always #4 clk = ~clk;

  rx_line_monitor dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rx_pin_i(pin), .bit_tick_i(tick),
    .char9_i(char9), .brk_en_i(brk_en), .rx_inv_i(inv), .two_wire_i(two_w),
    .brk_irq_en_i(ie_b), .edge_irq_en_i(ie_e), .wr_en_i(wr), .wr_data_i(wdata),
    .brk_flag_o(brk_f), .edge_flag_o(edge_f), .irq_o(irq)
  );

  function automatic bit exp_irq();
    return (m_brk && ie_b) || (m_edge && ie_e);
  endfunction

  function automatic int thr();
    return char9 ? 12 : 11;
  endfunction

  task automatic model_tick();
    bit lvl = pin ^ inv;
    int nxt;
    if (lvl) m_cnt = 0;
    else begin
      nxt = (m_cnt < 15) ? m_cnt + 1 : m_cnt;
      if (brk_en && m_cnt < 15 && nxt == thr()) m_brk = 1'b1;
      m_cnt = nxt;
    end
  endtask

  task automatic check(input string tag);
    vectors++;
    if (brk_f !== m_brk || edge_f !== m_edge || irq !== exp_irq()) begin
      fails++;
      $display("FAIL %s: brk/edge/irq actual %b%b%b expected %b%b%b",
               tag, brk_f, edge_f, irq, m_brk, m_edge, exp_irq());
    end
  endtask

  task automatic send_bit(input logic b, input bit clr_with_tick, input string tag);
    logic old;
    @(negedge clk);
    old = pin;
    pin = b;
    if (two_w && old != b && (inv ? b : !b)) m_edge = 1'b1;
    repeat (4) @(negedge clk);
    tick = 1'b1;
    if (clr_with_tick) begin
      wr = 1'b1; wdata = 8'hC0;
      m_brk = 1'b0; m_edge = 1'b0;
    end
    model_tick();
    @(negedge clk);
    tick = 1'b0; wr = 1'b0; wdata = 8'h00;
    check(tag);
  endtask

  task automatic write_clr(input logic [7:0] d, input string tag);
    @(negedge clk);
    wr = 1'b1; wdata = d;
    if (d[7]) m_brk = 1'b0;
    if (d[6]) m_edge = 1'b0;
    @(negedge clk);
    wr = 1'b0; wdata = 8'h00;
    check(tag);
  endtask

  task automatic set_cfg(input logic c9, input logic be, input logic iv,
                         input logic tw, input logic ib, input logic iee,
                         input string tag);
    @(negedge clk);
    char9 = c9; brk_en = be; inv = iv; two_w = tw; ie_b = ib; ie_e = iee;
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset");

    set_cfg(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "R9 cfg");
    send_bit(1'b1, 1'b0, "R2 idle");
    // R5 first zero is a falling edge
    send_bit(1'b0, 1'b0, "R5 falling");
    write_clr(8'h40, "R7 edge clear");
    for (int i = 2; i <= 10; i++) send_bit(1'b0, 1'b0, "R2 below 11");
    send_bit(1'b0, 1'b0, "R2 11th zero");
    for (int i = 0; i < 6; i++) send_bit(1'b0, 1'b0, "R4 long run");
    write_clr(8'h3F, "R7 zeros ignored");
    write_clr(8'h80, "R7 break clear");
    for (int i = 0; i < 6; i++) send_bit(1'b0, 1'b0, "R4 once per run");
    send_bit(1'b1, 1'b0, "R5 rising ignored");
    set_cfg(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R4 disable");
    write_clr(8'hC0, "R7 clear both");
    for (int i = 0; i < 12; i++) send_bit(1'b0, 1'b0, "R4 disabled run");
    send_bit(1'b1, 1'b0, "R4 restart");
    set_cfg(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "R3 cfg");
    write_clr(8'hC0, "R7 clear both");
    for (int i = 0; i < 11; i++) send_bit(1'b0, 1'b0, "R3 11 not enough");
    send_bit(1'b0, 1'b0, "R3 12th zero");
    // R9 enable gating
    set_cfg(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R9 brk masked");
    write_clr(8'hC0, "R7 clear both");
    // R5 inverted: pin is 0, data is 1; rising edge is active
    set_cfg(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R5 inv cfg");
    send_bit(1'b1, 1'b0, "R5 rising with inv");
    write_clr(8'h40, "R7 edge clear");
    send_bit(1'b0, 1'b0, "R5 falling ignored inv");
    // R6 no edges outside two-wire mode
    set_cfg(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R6 cfg");
    send_bit(1'b1, 1'b0, "R6 rise");
    send_bit(1'b0, 1'b0, "R6 fall ignored");
    // R8 set beats clear in the same cycle
    set_cfg(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "R8 cfg");
    send_bit(1'b1, 1'b0, "R8 idle");
    write_clr(8'hC0, "R7 clear both");
    for (int i = 0; i < 10; i++) send_bit(1'b0, 1'b0, "R8 run");
    send_bit(1'b0, 1'b1, "R8 set wins");
    set_cfg(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R9 edge masked");
    set_cfg(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R9 all masked");

    void'($urandom(32'h1D5E_77A1));
    for (int n = 0; n < 500; n++) begin
      int op = $urandom_range(0, 99);
      if (op < 75) begin
        send_bit(($urandom_range(0, 99) < 85) ? (1'b0 ^ inv) : (1'b1 ^ inv),
                 ($urandom_range(0, 99) < 3), "R2 R3 R4 R5 R6 R8 random bit");
      end else if (op < 88) begin
        write_clr(8'($urandom()), "R7 random write");
      end else begin
        set_cfg(1'($urandom()), ($urandom_range(0, 9) < 8),
                ($urandom_range(0, 9) < 2), ($urandom_range(0, 9) < 7),
                1'($urandom()), 1'($urandom()), "R9 random cfg");
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule